// File: doc/BRIEF.md
# Prioritised External Interrupt Controller with Claim and Complete

This block gathers up to 31 level-sensitive interrupt lines from peripherals and presents one interrupt request to a single processor context. Each source has a 3-bit priority. Software also sets an enable mask and a 3-bit threshold. A source can win only when all of these hold: it is pending, it is enabled, and its priority is strictly above the threshold.

Software services an interrupt in three steps. It reads the claim register, which returns the winning source ID and marks that source as in service. It handles the device. It then writes the same ID back to the claim register to complete. A source in service cannot become pending again until it has been completed. The block is reached over a simple 32-bit register bus with byte addresses. Only word-aligned accesses at the fixed offsets below decode.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, all priorities, the enable mask, the threshold, the pending bits and the in-service state are zero. The interrupt output is low and a claim read returns 0.
- R2: The priority word of source n is at byte offset 4*n (n from 1 to 31). The threshold is at offset 0x200000. Both keep only write bits [2:0], ignore the upper bits, and read back zero-extended. The priority word of ID 0 always reads 0.
- R3: The pending word is at offset 0x001000 and the enable word at offset 0x002000. In both, bit n belongs to source n. Bit 0 reads 0 in both and cannot be set. Writes to the pending word have no effect.
- R4: Input line k-1 drives source k. It passes through two synchronising flops before pending samples it. If the line rises just after a clock edge, its pending bit is not visible before the third following rising edge, and it is visible after that edge.
- R5: A source takes part in arbitration only if its priority is strictly greater than the threshold. A threshold of 7 blocks every source.
- R6: A read of offset 0x200004 returns the ID of the eligible, enabled, pending source with the highest priority. Among equal priorities the lowest ID wins. The read returns 0 when no source qualifies.
- R7: A claim read that returns a nonzero ID clears that source's pending bit and puts it in service. While a source is in service, its input is not latched into pending.
- R8: Writing an in-service ID to offset 0x200004 takes it out of service. If its input is still high, it becomes pending again. A write of an ID that is not in service, or of a value above 31, changes nothing.
- R9: The interrupt output is high exactly when some source qualifies under R6. It follows a register change in the cycle after that change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_src_i | input | 31 | Level interrupt lines; bit k-1 is source k |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 24 | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the strobe |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
Directed cases cover the arbitration boundaries:
- Two sources share the top priority while a lower one waits, which separates lowest-ID tie breaking from plain priority ordering.
- The threshold is stepped to 7 and to just below a source's priority, which checks the strict "greater than" comparison.
- A line is raised and pending is sampled on both sides of the third clock edge, which measures the synchroniser latency.
- A line is held high across a claim, an out-of-range complete and a real complete, which separates in-service blocking from ordinary re-pending.

Random rounds draw priorities, masks, thresholds and line levels, with sparse lines and low thresholds favoured. A bench model predicts the pending word, the output and every claimed ID, so mis-ordering or a stale mask shows up as a wrong ID.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int PRIO_W = 3;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_PEND  = 24'h001000;
  localparam logic [ADDR_W-1:0] OFS_EN    = 24'h002000;
  localparam logic [ADDR_W-1:0] OFS_THR   = 24'h200000;
  localparam logic [ADDR_W-1:0] OFS_CLAIM = 24'h200004;

  typedef logic [PRIO_W-1:0] prio_t;

  // Source priority clears the threshold (strict comparison).
  function automatic logic above_thr(prio_t p, prio_t t);
    return p > t;
  endfunction

  // Candidate displaces the current best only when strictly higher,
  // so scanning in ascending ID order keeps the lowest ID on a tie.
  function automatic logic beats(prio_t cand, prio_t best);
    return cand > best;
  endfunction
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int W = 31
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= async_i[b];
        s2_q <= s1_q;
      end
    end
    assign sync_o[b] = s2_q;
  end
endmodule

// File: rtl/ext_irq_gateway.sv
module ext_irq_gateway #(
  parameter int NID  = 32,
  parameter int ID_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NID-1:0]  level_i,
  input  logic            claim_fire_i,
  input  logic [ID_W-1:0] claim_id_i,
  input  logic            done_fire_i,
  input  logic [ID_W-1:0] done_id_i,
  output logic [NID-1:0]  pend_o,
  output logic [NID-1:0]  insvc_o
);
  assign pend_o[0]  = 1'b0;
  assign insvc_o[0] = 1'b0;

  logic unused_lvl0;
  assign unused_lvl0 = level_i[0];

  for (genvar i = 1; i < NID; i++) begin : g_src
    logic pend_q, insvc_q;
    logic take, release_ok;
    assign take       = claim_fire_i && (claim_id_i == ID_W'(i));
    assign release_ok = done_fire_i && (done_id_i == ID_W'(i)) && insvc_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q  <= 1'b0;
        insvc_q <= 1'b0;
      end else if (take) begin
        pend_q  <= 1'b0;
        insvc_q <= 1'b1;
      end else begin
        if (release_ok) insvc_q <= 1'b0;
        if (!insvc_q && level_i[i]) pend_q <= 1'b1;
      end
    end

    assign pend_o[i]  = pend_q;
    assign insvc_o[i] = insvc_q;
  end
endmodule

// File: rtl/ext_irq_arbiter.sv
module ext_irq_arbiter
  import ext_irq_pkg::*;
#(
  parameter int NID  = 32,
  parameter int ID_W = 5
) (
  input  logic [NID-1:0]        pend_i,
  input  logic [NID-1:0]        en_i,
  input  logic [NID*PRIO_W-1:0] prio_flat_i,
  input  prio_t                 thr_i,
  output logic [ID_W-1:0]       best_id_o,
  output logic                  found_o
);
  prio_t best_p;
  prio_t cand_p;

  always_comb begin
    best_id_o = '0;
    best_p    = '0;
    cand_p    = '0;
    for (int i = 1; i < NID; i++) begin
      cand_p = prio_flat_i[i*PRIO_W +: PRIO_W];
      if (pend_i[i] && en_i[i] && above_thr(cand_p, thr_i) && beats(cand_p, best_p)) begin
        best_id_o = ID_W'(i);
        best_p    = cand_p;
      end
    end
  end

  assign found_o = (best_id_o != '0);

  logic unused_p0;
  assign unused_p0 = ^{prio_flat_i[PRIO_W-1:0], pend_i[0], en_i[0]};
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int NUM_SRC = 31
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC-1:0]  irq_src_i,
  input  logic                bus_sel_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  output logic                irq_o
);
  localparam int NID  = NUM_SRC + 1;
  localparam int ID_W = $clog2(NID);
  localparam logic [NID-1:0] ID_MASK = {{NUM_SRC{1'b1}}, 1'b0};

  // bus decode
  logic wr_fire, rd_fire;
  logic hit_prio, hit_pend, hit_en, hit_thr, hit_claim;
  logic [9:0] prio_idx;

  assign wr_fire   = bus_sel_i && bus_we_i;
  assign rd_fire   = bus_sel_i && !bus_we_i;
  assign hit_prio  = (bus_addr_i[ADDR_W-1:12] == '0) && (bus_addr_i[1:0] == 2'b00);
  assign hit_pend  = (bus_addr_i == OFS_PEND);
  assign hit_en    = (bus_addr_i == OFS_EN);
  assign hit_thr   = (bus_addr_i == OFS_THR);
  assign hit_claim = (bus_addr_i == OFS_CLAIM);
  assign prio_idx  = bus_addr_i[11:2];

  // configuration registers
  prio_t           prio_q [NID];
  logic [NID-1:0]  enable_q;
  prio_t           thresh_q;
  logic [NID*PRIO_W-1:0] prio_flat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NID; i++) prio_q[i] <= '0;
      enable_q <= '0;
      thresh_q <= '0;
    end else if (wr_fire) begin
      for (int i = 1; i < NID; i++)
        if (hit_prio && prio_idx == 10'(i)) prio_q[i] <= bus_wdata_i[PRIO_W-1:0];
      if (hit_en)  enable_q <= bus_wdata_i[NID-1:0] & ID_MASK;
      if (hit_thr) thresh_q <= bus_wdata_i[PRIO_W-1:0];
    end
  end

  for (genvar i = 0; i < NID; i++) begin : g_flat
    assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
  end

  // source path
  logic [NUM_SRC-1:0] sync_lvl;
  logic [NID-1:0]     level_full;
  logic [NID-1:0]     pend_w, insvc_w;

  ext_irq_sync #(.W(NUM_SRC)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (irq_src_i),
    .sync_o  (sync_lvl)
  );

  assign level_full = {sync_lvl, 1'b0};

  // claim / complete events
  logic            claim_fire, done_fire, done_ok;
  logic [ID_W-1:0] best_id, done_id;
  logic            found;

  assign claim_fire = rd_fire && hit_claim;
  assign done_ok    = (bus_wdata_i < DATA_W'(NID));
  assign done_fire  = wr_fire && hit_claim && done_ok;
  assign done_id    = bus_wdata_i[ID_W-1:0];

  ext_irq_gateway #(.NID(NID), .ID_W(ID_W)) u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .level_i      (level_full),
    .claim_fire_i (claim_fire),
    .claim_id_i   (best_id),
    .done_fire_i  (done_fire),
    .done_id_i    (done_id),
    .pend_o       (pend_w),
    .insvc_o      (insvc_w)
  );

  ext_irq_arbiter #(.NID(NID), .ID_W(ID_W)) u_arb (
    .pend_i      (pend_w),
    .en_i        (enable_q),
    .prio_flat_i (prio_flat),
    .thr_i       (thresh_q),
    .best_id_o   (best_id),
    .found_o     (found)
  );

  assign irq_o = found;

  // read mux
  always_comb begin
    bus_rdata_o = '0;
    if (hit_prio) begin
      for (int i = 1; i < NID; i++)
        if (prio_idx == 10'(i)) bus_rdata_o = DATA_W'(prio_q[i]);
    end else if (hit_pend) bus_rdata_o = DATA_W'(pend_w);
    else if (hit_en)     bus_rdata_o = DATA_W'(enable_q);
    else if (hit_thr)    bus_rdata_o = DATA_W'(thresh_q);
    else if (hit_claim)  bus_rdata_o = DATA_W'(best_id);
  end
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk
  import ext_irq_pkg::*;
#(
  parameter int NID  = 32,
  parameter int ID_W = 5
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  irq_o,
  input logic [NID-1:0]        pend_w,
  input logic [NID-1:0]        insvc_w,
  input logic [NID-1:0]        enable_q,
  input logic [NID-1:0]        level_full,
  input logic [NID*PRIO_W-1:0] prio_flat,
  input prio_t                 thresh_q,
  input logic                  claim_fire,
  input logic [ID_W-1:0]       best_id,
  input logic                  done_fire,
  input logic [ID_W-1:0]       done_id
);
  assert_null_source_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_w[0] && !enable_q[0] && !insvc_w[0] && prio_flat[PRIO_W-1:0] == '0);

  assert_pend_needs_level_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_w & ~$past(pend_w) & ~$past(level_full)) == '0));

  assert_winner_above_thr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (best_id != '0) |-> (prio_flat[best_id*PRIO_W +: PRIO_W] > thresh_q));

  assert_winner_live_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (best_id != '0) |-> (pend_w[best_id] && enable_q[best_id]));

  assert_claim_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_fire && best_id != '0) |=> (!pend_w[$past(best_id)] && insvc_w[$past(best_id)]));

  assert_no_pend_in_service_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_w & insvc_w) == '0);

  assert_stray_complete_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_fire && !insvc_w[done_id] && !claim_fire) |=> (insvc_w == $past(insvc_w)));

  assert_irq_low_no_winner_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (best_id == '0));
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(.NID(NID), .ID_W(ID_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_o      (irq_o),
  .pend_w     (pend_w),
  .insvc_w    (insvc_w),
  .enable_q   (enable_q),
  .level_full (level_full),
  .prio_flat  (prio_flat),
  .thresh_q   (thresh_q),
  .claim_fire (claim_fire),
  .best_id    (best_id),
  .done_fire  (done_fire),
  .done_id    (done_id)
);

// File: tb/test_ext_irq_ctrl.sv
module test_ext_irq_ctrl;
  localparam int NS = 31;
  localparam logic [23:0] A_PEND = 24'h001000, A_EN = 24'h002000,
                          A_THR = 24'h200000, A_CLM = 24'h200004;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic sel = 1'b0, we = 1'b0;
  logic [23:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;

  int checks = 0, errors = 0;

  bit [2:0]  m_prio [32];
  bit [31:0] m_en, m_pend, m_insvc;
  bit [2:0]  m_thr;

  always #2 clk = ~clk;

  ext_irq_ctrl #(.NUM_SRC(NS)) i_ext_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_src_i(src), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // tasks start and end at a falling edge
  task automatic wr(logic [23:0] a, logic [31:0] d);
    sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; we = 0;
  endtask

  task automatic rd(logic [23:0] a, output logic [31:0] d);
    sel = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    sel = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit [4:0] exp_claim();
    bit [4:0] best = 0;
    bit [2:0] bp = 0;
    for (int i = 1; i < 32; i++)
      if (m_pend[i] && m_en[i] && m_prio[i] > m_thr && m_prio[i] > bp) begin
        best = 5'(i); bp = m_prio[i];
      end
    return best;
  endfunction

  task automatic do_reset();
    rst_n = 0; src = '0;
    idle(3);
    rst_n = 1;
    idle(1);
    for (int i = 0; i < 32; i++) m_prio[i] = 0;
    m_en = 0; m_pend = 0; m_insvc = 0; m_thr = 0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    bit [4:0] e;
    bit [31:0] s;
    @(negedge clk);
    do_reset();

    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    rd(A_PEND, v); check("R1 pending", v, 0);
    rd(A_EN, v);   check("R1 enable", v, 0);
    rd(A_THR, v);  check("R1 threshold", v, 0);
    rd(24'h000014, v); check("R1 priority5", v, 0);
    rd(A_CLM, v);  check("R1 claim", v, 0);

    // R2 register widths
    wr(24'h000008, 32'hFFFF_FFFD); rd(24'h000008, v); check("R2 prio2 low bits", v, 5);
    wr(24'h000000, 32'h7);        rd(24'h000000, v); check("R2 prio0 zero", v, 0);
    wr(A_THR, 32'h0000_00FA);      rd(A_THR, v);     check("R2 thr low bits", v, 2);

    // R3 bitmaps
    wr(A_EN, 32'hFFFF_FFFF); rd(A_EN, v); check("R3 enable bit0", v, 32'hFFFF_FFFE);
    wr(A_PEND, 32'hFFFF_FFFF); rd(A_PEND, v); check("R3 pending write ignored", v, 0);

    // R4 synchroniser latency, source 5 = line 4
    wr(A_THR, 0); wr(24'h000014, 1);
    src[4] = 1;
    idle(2);
    rd(A_PEND, v); check("R4 not before third edge", v, 0);
    rd(A_PEND, v); check("R4 after third edge", v, 32'h20);
    rd(A_CLM, v);  check("R6 single source", v, 5);
    src[4] = 0;
    wr(A_CLM, 5);

    // R6 tie break and ordering
    do_reset();
    wr(24'h00000C, 5); wr(24'h000024, 5); wr(24'h000030, 2);
    wr(A_EN, 32'hFFFF_FFFE); wr(A_THR, 1);
    src = '0; src[2] = 1; src[8] = 1; src[11] = 1;
    idle(4);
    check("R9 irq with eligible", 32'(irq), 1);
    rd(A_CLM, v); check("R6 tie lower id", v, 3);
    rd(A_CLM, v); check("R6 tie next", v, 9);
    rd(A_CLM, v); check("R6 lower priority", v, 12);
    rd(A_CLM, v); check("R6 none left", v, 0);
    check("R9 irq low all claimed", 32'(irq), 0);
    rd(A_PEND, v); check("R7 claimed not repended", v, 0);
    wr(A_CLM, 3); wr(A_CLM, 9); wr(A_CLM, 12);
    idle(2);
    rd(A_PEND, v); check("R8 repend after complete", v, 32'h1208);

    // R5 threshold
    wr(A_THR, 7); check("R5 thr7 irq", 32'(irq), 0);
    rd(A_CLM, v); check("R5 thr7 claim", v, 0);
    wr(A_THR, 4); rd(A_CLM, v); check("R5 thr4 claim", v, 3);
    rd(A_CLM, v); check("R5 thr4 second", v, 9);
    rd(A_CLM, v); check("R5 prio2 below thr4", v, 0);
    wr(A_THR, 5); wr(A_CLM, 9); idle(3);
    check("R5 prio equal thr blocked", 32'(irq), 0);
    wr(A_THR, 0); idle(1);

    // R8 ignored completes
    wr(A_CLM, 32'h43); wr(A_CLM, 32'h20);
    idle(4);
    rd(A_PEND, v); check("R8 out-of-range complete ignored", v, 32'h1200);
    rd(A_CLM, v); check("R8 claim after stray", v, 9);
    wr(A_CLM, 9); wr(A_CLM, 3); idle(3);
    rd(A_PEND, v); check("R8 real complete", v, 32'h1208);

    // random rounds
    do_reset();
    void'($urandom(32'd20240611));
    for (int r = 0; r < 40; r++) begin
      for (int id = 1; id < 32; id++) begin
        m_prio[id] = 3'($urandom % 8);
        wr(24'(4 * id), ($urandom & 32'hFFFF_FFF8) | 32'(m_prio[id]));
      end
      m_en = $urandom & 32'hFFFF_FFFE;
      wr(A_EN, m_en);
      m_thr = (r % 4 == 0) ? 3'($urandom % 8) : 3'($urandom % 3);
      wr(A_THR, ($urandom & 32'hFFFF_FFF8) | 32'(m_thr));
      s = $urandom & $urandom;
      src = s[NS-1:0];
      idle(4);
      m_pend = m_pend | ({s[NS-1:0], 1'b0} & ~m_insvc);
      rd(A_PEND, v); check("R3 random pending", v, m_pend);
      e = exp_claim();
      check("R9 random irq", 32'(irq), 32'(e != 0));
      rd(A_CLM, v); check("R6 random claim", v, 32'(e));
      if (e != 0) begin
        m_pend[e] = 0; m_insvc[e] = 1;
      end
      if (r % 3 == 0) begin
        for (int id = 31; id > 0; id--)
          if (!m_insvc[id]) begin wr(A_CLM, 32'(id)); break; end
      end else if (e != 0) begin
        wr(A_CLM, 32'(e)); m_insvc[e] = 0;
      end
      if (r % 5 == 4)
        for (int id = 1; id < 32; id++)
          if (m_insvc[id]) begin wr(A_CLM, 32'(id)); m_insvc[id] = 0; end
      idle(4);
      m_pend = m_pend | ({s[NS-1:0], 1'b0} & ~m_insvc);
      rd(A_PEND, v); check("R7 R8 pending after completes", v, m_pend);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule